// File: doc/BRIEF.md
# UART FIFO interrupt request generator

This block turns status events from an asynchronous serial port into three interrupt requests: receive-complete, transmit-enable and transmit-all-done. The port works in one of two modes. In single-buffer mode every stored or sent character raises a request. In FIFO mode the receive and transmit requests are throttled by programmable 4-bit trigger counts. The all-done request exists only in FIFO mode. It reports that both the transmit FIFO and the shift register have drained.

Baud generation, framing and the FIFO storage sit outside the block. They arrive as single-cycle event strobes and as an occupancy level. Each request output comes from a register. It is either a one-clock pulse (immediate mode) or a level that stays up until software acknowledges it (pending mode). A transmit FIFO clear strobe cancels a held transmit-enable request and restarts the transmit trigger count.

Top module: `uart_irq_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, all three request outputs are low.
- R2: In single mode with reception enabled, an `rx_push` strobe raises `irq_rx` in the clock cycle after the strobe.
- R3: While `rx_en` is low, `rx_push` raises no receive request in either mode.
- R4: In FIFO mode (`fifo_mode`=1), `irq_rx` rises only after the `rx_trig`-th `rx_push` since the counter was last cleared. Earlier strobes raise nothing.
- R5: A trigger value of 0 acts like 1, so every character raises a request.
- R6: In single mode, `irq_tx` rises after a `tx_frame_done` strobe only if `tx_hold_empty` is high in the same cycle.
- R7: In FIFO mode, `irq_tx` rises after the `tx_trig`-th `tx_pop` strobe.
- R8: In FIFO mode with `tx_en` high, `irq_done` rises once when the transmitter becomes empty (`tx_fifo_level`=0 and `tx_sr_busy`=0 after being non-empty). It does not repeat while the transmitter stays idle. In single mode it never rises.
- R9: In immediate mode (`hold_mode`=0), each request is a pulse exactly one clock wide.
- R10: In pending mode (`hold_mode`=1), a request stays high until its acknowledge input is pulsed. A new event in the acknowledge cycle keeps it high.
- R11: `tx_fifo_clr` drops a held `irq_tx` and restarts the transmit trigger count from zero.
- R12: A trigger counter restarts from zero when its request fires and when its direction is disabled.
- R13: An all-done request caused by an underrun leaves the transmit trigger count untouched. Counting continues with the next `tx_pop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Reception enable |
| tx_en | input | 1 | Transmission enable |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = single-buffer mode |
| hold_mode | input | 1 | 1 = pending (held level), 0 = immediate (pulse) |
| rx_trig | input | 4 | Receive trigger count (0 treated as 1) |
| tx_trig | input | 4 | Transmit trigger count (0 treated as 1) |
| tx_fifo_clr | input | 1 | Transmit FIFO clear strobe |
| rx_ack | input | 1 | Acknowledge for held receive request |
| tx_ack | input | 1 | Acknowledge for held transmit request |
| done_ack | input | 1 | Acknowledge for held all-done request |
| rx_push | input | 1 | Character stored in the receive register or FIFO |
| tx_frame_done | input | 1 | Frame has left the transmit shift register |
| tx_hold_empty | input | 1 | Transmit data register is empty (single mode) |
| tx_pop | input | 1 | Character moved from the transmit FIFO to the shift register |
| tx_fifo_level | input | 5 | Transmit FIFO occupancy |
| tx_sr_busy | input | 1 | Transmit shift register holds a character |
| irq_rx | output | 1 | Receive-complete request |
| irq_tx | output | 1 | Transmit-enable request |
| irq_done | output | 1 | Transmit-all-done request |

## Verification
A trigger counter that drifts from the true character count shows up at the ports at the next expected trigger point. The request either arrives one or more strobes early or late, so a sequence of N strobes exposes the error within N cycles. A stale empty-history register shows as a missing or repeated `irq_done` on the very next drain. A wrong output-stage decision shows one cycle after the event: a pulse that lasts too long, or a held level that drops without an acknowledge.

// File: rtl/uig_pkg.sv
package uig_pkg;
  localparam int TRIG_W = 4;

  // A trigger value of zero behaves as one
  function automatic logic [TRIG_W-1:0] eff_trig(input logic [TRIG_W-1:0] v);
    return (v == '0) ? TRIG_W'(1) : v;
  endfunction
endpackage

// File: rtl/uig_trig_cnt.sv
module uig_trig_cnt
  import uig_pkg::*;
#(
  parameter int TW = TRIG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          ev,
  input  logic [TW-1:0] trig,
  output logic          fire
);
  logic [TW-1:0] cnt;
  logic [TW-1:0] eff;
  logic          hit;

  always_comb begin
    eff  = (trig == '0) ? TW'(1) : trig;
    hit  = ({1'b0, cnt} + (TW+1)'(1)) >= {1'b0, eff};
    fire = ev & ~clr & hit;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (ev)    cnt <= hit ? '0 : cnt + TW'(1);
  end
endmodule

// File: rtl/uig_req_out.sv
module uig_req_out (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic fire,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)       irq <= 1'b0;
    else if (hold) irq <= fire | (irq & ~clr);
    else           irq <= fire;
  end
endmodule

// File: rtl/uig_done_det.sv
module uig_done_det #(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [LW-1:0] level,
  input  logic          busy,
  output logic          fire
);
  logic empty_now;
  logic empty_q;

  always_comb begin
    empty_now = (level == '0) & ~busy;
    fire      = en & empty_now & ~empty_q;
  end

  always_ff @(posedge clk) begin
    if (rst) empty_q <= 1'b1;
    else     empty_q <= empty_now;
  end
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
  import uig_pkg::*;
#(
  parameter int TW = TRIG_W,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic          tx_en,
  input  logic          fifo_mode,
  input  logic          hold_mode,
  input  logic [TW-1:0] rx_trig,
  input  logic [TW-1:0] tx_trig,
  input  logic          tx_fifo_clr,
  input  logic          rx_ack,
  input  logic          tx_ack,
  input  logic          done_ack,
  input  logic          rx_push,
  input  logic          tx_frame_done,
  input  logic          tx_hold_empty,
  input  logic          tx_pop,
  input  logic [LW-1:0] tx_fifo_level,
  input  logic          tx_sr_busy,
  output logic          irq_rx,
  output logic          irq_tx,
  output logic          irq_done
);
  localparam int NREQ = 3;

  logic rx_ev, rx_cnt_clr, rx_cnt_fire;
  logic tx_ev, tx_cnt_clr, tx_cnt_fire, tx_single;
  logic done_fire;
  logic [NREQ-1:0] fire_v, clr_v, irq_v;

  always_comb begin
    rx_ev      = rx_en & rx_push;
    rx_cnt_clr = ~rx_en | ~fifo_mode;
    tx_ev      = tx_en & fifo_mode & tx_pop;
    tx_cnt_clr = ~tx_en | ~fifo_mode | tx_fifo_clr;
    tx_single  = tx_en & tx_frame_done & tx_hold_empty & ~tx_fifo_clr;
  end

  uig_trig_cnt #(.TW(TW)) u_rx_cnt (
    .clk(clk), .rst(rst), .clr(rx_cnt_clr), .ev(rx_ev & fifo_mode),
    .trig(rx_trig), .fire(rx_cnt_fire)
  );

  uig_trig_cnt #(.TW(TW)) u_tx_cnt (
    .clk(clk), .rst(rst), .clr(tx_cnt_clr), .ev(tx_ev),
    .trig(tx_trig), .fire(tx_cnt_fire)
  );

  uig_done_det #(.LW(LW)) u_done (
    .clk(clk), .rst(rst), .en(fifo_mode & tx_en),
    .level(tx_fifo_level), .busy(tx_sr_busy), .fire(done_fire)
  );

  always_comb begin
    fire_v[0] = fifo_mode ? rx_cnt_fire : rx_ev;
    fire_v[1] = fifo_mode ? tx_cnt_fire : tx_single;
    fire_v[2] = done_fire;
    clr_v[0]  = rx_ack;
    clr_v[1]  = tx_ack | tx_fifo_clr;
    clr_v[2]  = done_ack;
  end

  for (genvar g = 0; g < NREQ; g++) begin : g_req
    uig_req_out u_out (
      .clk(clk), .rst(rst), .hold(hold_mode),
      .fire(fire_v[g]), .clr(clr_v[g]), .irq(irq_v[g])
    );
  end

  assign irq_rx   = irq_v[0];
  assign irq_tx   = irq_v[1];
  assign irq_done = irq_v[2];
endmodule

// File: rtl/uart_irq_gen_chk.sv
module uart_irq_gen_chk (
  input logic clk,
  input logic rst,
  input logic rx_en,
  input logic fifo_mode,
  input logic hold_mode,
  input logic tx_fifo_clr,
  input logic rx_ack,
  input logic rx_push,
  input logic irq_rx,
  input logic irq_tx,
  input logic irq_done
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!irq_rx && !irq_tx && !irq_done));

  // R2
  single_rx_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_en && !fifo_mode && rx_push) |=> irq_rx);

  // R3
  rx_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !hold_mode) |=> !irq_rx);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    (!fifo_mode && !hold_mode) |=> !irq_done);

  // R8
  done_once_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_done && !hold_mode) |=> !irq_done);

  // R10
  held_rx_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_mode && irq_rx && !rx_ack) |=> irq_rx);

  // R11
  clr_drops_tx_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_mode && tx_fifo_clr) |=> !irq_tx);
endmodule

bind uart_irq_gen uart_irq_gen_chk u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .fifo_mode(fifo_mode),
  .hold_mode(hold_mode), .tx_fifo_clr(tx_fifo_clr), .rx_ack(rx_ack),
  .rx_push(rx_push), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_done(irq_done)
);

// File: tb/uart_irq_gen_test.sv
`timescale 1ns/1ps
module uart_irq_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 0, tx_en = 0, fifo_mode = 0, hold_mode = 0;
  logic [3:0] rx_trig = 0, tx_trig = 0;
  logic       tx_fifo_clr = 0, rx_ack = 0, tx_ack = 0, done_ack = 0;
  logic       rx_push = 0, tx_frame_done = 0, tx_hold_empty = 0, tx_pop = 0;
  logic [4:0] tx_fifo_level = 0;
  logic       tx_sr_busy = 0;
  logic       irq_rx, irq_tx, irq_done;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  uart_irq_gen uut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .tx_en(tx_en),
    .fifo_mode(fifo_mode), .hold_mode(hold_mode),
    .rx_trig(rx_trig), .tx_trig(tx_trig), .tx_fifo_clr(tx_fifo_clr),
    .rx_ack(rx_ack), .tx_ack(tx_ack), .done_ack(done_ack),
    .rx_push(rx_push), .tx_frame_done(tx_frame_done),
    .tx_hold_empty(tx_hold_empty), .tx_pop(tx_pop),
    .tx_fifo_level(tx_fifo_level), .tx_sr_busy(tx_sr_busy),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_done(irq_done)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one strobe cycle, then strobes removed
  task automatic push_rx();
    rx_push = 1; tick(); rx_push = 0;
  endtask

  task automatic pop_tx();
    tx_pop = 1; tick(); tx_pop = 0;
  endtask

  task automatic t_reset();
    rst = 1; tick(); tick();
    check("R1 irq_rx in reset", irq_rx, 0);
    rst = 0; tick();
    check("R1 irq_tx after reset", irq_tx, 0);
    check("R1 irq_done after reset", irq_done, 0);
  endtask

  task automatic t_single_rx();
    fifo_mode = 0; hold_mode = 0; rx_en = 1;
    push_rx();
    check("R2 single rx request", irq_rx, 1);
    tick();
    check("R9 rx pulse one clock", irq_rx, 0);
  endtask

  task automatic t_rx_disabled();
    rx_en = 0; fifo_mode = 0;
    push_rx();
    check("R3 single rx disabled", irq_rx, 0);
    fifo_mode = 1; rx_trig = 1;
    push_rx();
    check("R3 fifo rx disabled", irq_rx, 0);
  endtask

  task automatic t_fifo_rx();
    fifo_mode = 1; rx_en = 1; rx_trig = 3; tick();
    push_rx(); check("R4 first push quiet", irq_rx, 0);
    push_rx(); check("R4 second push quiet", irq_rx, 0);
    push_rx(); check("R4 third push fires", irq_rx, 1);
    push_rx(); check("R12 restart after fire 1", irq_rx, 0);
    push_rx(); check("R12 restart after fire 2", irq_rx, 0);
    push_rx(); check("R12 restart after fire 3", irq_rx, 1);
    tick();
  endtask

  task automatic t_trig_zero();
    fifo_mode = 1; rx_en = 1; rx_trig = 0;
    push_rx(); check("R5 zero trigger push 1", irq_rx, 1);
    push_rx(); check("R5 zero trigger push 2", irq_rx, 1);
    tick();
  endtask

  task automatic t_disable_restart();
    rx_trig = 3;
    push_rx(); push_rx();
    rx_en = 0; tick(); rx_en = 1;
    push_rx(); push_rx();
    check("R12 disable restarts count", irq_rx, 0);
    push_rx();
    check("R12 third after restart fires", irq_rx, 1);
    tick();
  endtask

  task automatic t_single_tx();
    fifo_mode = 0; tx_en = 1;
    tx_frame_done = 1; tx_hold_empty = 0; tick(); tx_frame_done = 0;
    check("R6 data reg full no request", irq_tx, 0);
    tx_frame_done = 1; tx_hold_empty = 1; tick(); tx_frame_done = 0;
    check("R6 frame done and empty", irq_tx, 1);
    tick();
    check("R9 tx pulse one clock", irq_tx, 0);
    tx_hold_empty = 0;
  endtask

  task automatic t_fifo_tx();
    fifo_mode = 1; tx_en = 1; tx_trig = 2; tick();
    pop_tx(); check("R7 first pop quiet", irq_tx, 0);
    pop_tx(); check("R7 second pop fires", irq_tx, 1);
    tick();
  endtask

  task automatic t_done();
    fifo_mode = 1; tx_en = 1;
    tx_fifo_level = 2; tx_sr_busy = 1; tick();
    check("R8 busy no done", irq_done, 0);
    tx_fifo_level = 0; tick();
    check("R8 shift reg still busy", irq_done, 0);
    tx_sr_busy = 0; tick();
    check("R8 done on drain", irq_done, 1);
    tick();
    check("R8 done once 1", irq_done, 0);
    tick();
    check("R8 done once 2", irq_done, 0);
    fifo_mode = 0;
    tx_fifo_level = 1; tick(); tx_fifo_level = 0; tick();
    check("R8 no done in single mode", irq_done, 0);
  endtask

  task automatic t_underrun();
    fifo_mode = 1; tx_en = 1; tx_trig = 3; tick();
    tx_fifo_level = 1; tx_sr_busy = 1;
    pop_tx(); pop_tx();
    tx_fifo_level = 0; tx_sr_busy = 0; tick();
    check("R13 underrun done", irq_done, 1);
    check("R13 no tx yet", irq_tx, 0);
    tx_sr_busy = 1;
    pop_tx();
    check("R13 count kept across underrun", irq_tx, 1);
    tx_sr_busy = 0; tick();
  endtask

  task automatic t_pending();
    hold_mode = 1; fifo_mode = 0; rx_en = 1;
    push_rx();
    check("R10 held set", irq_rx, 1);
    tick(); tick();
    check("R10 held stays", irq_rx, 1);
    rx_ack = 1; rx_push = 1; tick(); rx_ack = 0; rx_push = 0;
    check("R10 new event beats ack", irq_rx, 1);
    rx_ack = 1; tick(); rx_ack = 0;
    check("R10 ack clears", irq_rx, 0);
  endtask

  task automatic t_clear();
    hold_mode = 1; fifo_mode = 0; tx_en = 1;
    tx_frame_done = 1; tx_hold_empty = 1; tick();
    tx_frame_done = 0; tx_hold_empty = 0;
    check("R11 held tx set", irq_tx, 1);
    tx_fifo_clr = 1; tick(); tx_fifo_clr = 0;
    check("R11 clear drops held tx", irq_tx, 0);
    fifo_mode = 1; tx_trig = 3; tick();
    pop_tx(); pop_tx();
    tx_fifo_clr = 1; tick(); tx_fifo_clr = 0;
    pop_tx(); pop_tx();
    check("R11 clear restarts count", irq_tx, 0);
    pop_tx();
    check("R11 third after clear fires", irq_tx, 1);
    tx_ack = 1; tick(); tx_ack = 0;
    check("R10 tx ack clears", irq_tx, 0);
    hold_mode = 0; tick();
  endtask

  initial begin
    t_reset();
    t_single_rx();
    t_rx_disabled();
    t_fifo_rx();
    t_trig_zero();
    t_disable_restart();
    t_single_tx();
    t_fifo_tx();
    t_done();
    t_underrun();
    t_pending();
    t_clear();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule